// File: doc/BRIEF.md
# Control Register Bank with Freeze Staging

This block is a byte-wide bank of control registers for a mixed-signal peripheral. A host reaches it through a simple synchronous bus: an 8-bit address, an 8-bit write data byte with a write strobe, and a read strobe with an 8-bit registered read data output. The bank holds a fixed identification byte, a power-control byte, two mute controls, two gain controls and two volume controls. Its outputs drive the analog sections directly.

The mute, gain and volume fields are double-buffered. Each has a staged copy that every write updates, and an active copy that drives the output. While the freeze bit in the power-control byte is set, only the staged copies change. When software clears freeze, every staged value moves to the active outputs on the same clock edge. A group of settings can therefore take effect together. The power-down bits and freeze itself are not buffered.

Top module: `ctrl_bank_freeze`

## Requirements
- R1: Address 01h reads as {4'b1100, REV[3:0]}, with the part code in bits 7:4. Writes to 01h change neither this value nor any output.
- R2: Address 02h holds freeze in bit 7, microphone power-down in bit 3, ADC power-down in bit 2, DAC power-down in bit 1 and device power-down in bit 0. Bits 6:4 read 0.
- R3: After a synchronous reset, 02h reads 01h (only device power-down set), freeze is 0, and every mute, gain and volume output and register reads 0.
- R4: With freeze clear, a write to a buffered field reaches its output on the clock edge that accepts the write.
- R5: With freeze set, writes to buffered fields leave the outputs unchanged, and a read of those registers returns the staged value.
- R6: A write to 02h that clears freeze moves every staged value to the outputs on that edge. The same write also applies its power-down bits.
- R7: The power-down bits and freeze take effect on the edge that accepts the write, whatever the freeze state.
- R8: The ADC hold output is high when ADC power-down or device power-down is set. The DAC hold output is high when DAC power-down or device power-down is set.
- R9: The buffered fields are DAC mute (03h bit 2), ADC mute (04h bit 2), gain A (07h bits 5:0), gain B (08h bits 5:0), volume A (0Ah) and volume B (0Bh). Other bits of these registers read 0 and ignore writes. Addresses not listed in R1, R2 or R9 read 00h.
- R10: Read data updates on the edge after a cycle with the read strobe high, and holds its value otherwise.
- R11: Setting device power-down keeps all register contents and active values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| freeze_on | output | 1 | Current freeze state |
| pd_mic | output | 1 | Microphone preamp power-down |
| pd_adc | output | 1 | ADC pair power-down |
| pd_dac | output | 1 | DAC pair power-down |
| pd_dev | output | 1 | Whole-device power-down |
| adc_hold | output | 1 | ADC reset hold |
| dac_hold | output | 1 | DAC reset hold |
| dac_mute | output | 1 | Active DAC mute |
| adc_mute | output | 1 | Active ADC mute |
| gain_a | output | 6 | Active gain A |
| gain_b | output | 6 | Active gain B |
| vol_a | output | 8 | Active volume A |
| vol_b | output | 8 | Active volume B |

## Verification
The assertions run on every cycle. They check the following:
- The active outputs stay still while freeze is held.
- An unfrozen volume write lands on the next edge.
- Power-down writes apply at once, and the hold outputs follow them.
- The identification byte reads back correctly.
- Read data holds when no read is strobed.

The bench scenarios cover the rest:
- A staged group of writes commits together when freeze clears, combined with a power-down change in the same write.
- Reserved and unmapped locations stay silent.
- Contents survive device power-down.
- A long random mix of reads and writes matches a reference model.

// File: rtl/ctrlbank_pkg.sv
package ctrlbank_pkg;
    localparam int DW  = 8;
    localparam int AW  = 8;
    localparam int NFZ = 6;

    localparam logic [AW-1:0] A_ID  = 8'h01;
    localparam logic [AW-1:0] A_PWR = 8'h02;
    localparam logic [3:0]    PART  = 4'hC;

    // buffered fields: 0 dac mute, 1 adc mute, 2 gain a, 3 gain b, 4 vol a, 5 vol b
    localparam logic [AW-1:0] FZ_ADDR [NFZ] = '{8'h03, 8'h04, 8'h07, 8'h08, 8'h0A, 8'h0B};
    localparam int            FZ_LSB  [NFZ] = '{2, 2, 0, 0, 0, 0};
    localparam int            FZ_W    [NFZ] = '{1, 1, 6, 6, 8, 8};

    typedef struct packed {
        logic freeze;
        logic pd_mic;
        logic pd_adc;
        logic pd_dac;
        logic pd_dev;
    } pwr_t;

    localparam pwr_t PWR_RST = '{freeze: 1'b0, pd_mic: 1'b0, pd_adc: 1'b0,
                                 pd_dac: 1'b0, pd_dev: 1'b1};
endpackage

// File: rtl/ctrlbank_fzfield.sv
module ctrlbank_fzfield
    import ctrlbank_pkg::*;
#(
    parameter int            W    = 8,
    parameter int            LSB  = 0,
    parameter logic [AW-1:0] ADDR = 8'h00
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    input  logic          freeze_d,
    output logic [W-1:0]  staged_q,
    output logic [W-1:0]  active_q
);
    typedef struct packed {
        logic [W-1:0] stg;
        logic [W-1:0] act;
    } fld_t;

    fld_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (wr_en && addr == ADDR) begin
            f_d.stg = wr_data[LSB +: W];
        end
        if (!freeze_d) begin
            f_d.act = f_d.stg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign staged_q = f_q.stg;
    assign active_q = f_q.act;
endmodule

// File: rtl/ctrlbank_rdmux.sv
module ctrlbank_rdmux
    import ctrlbank_pkg::*;
#(
    parameter logic [3:0] REV = 4'h0
) (
    input  logic [AW-1:0]           addr,
    input  pwr_t                    pwr,
    input  logic [NFZ-1:0][DW-1:0]  stg_bytes,
    output logic [DW-1:0]           data
);
    always_comb begin
        data = '0;
        if (addr == A_ID) begin
            data = {PART, REV};
        end else if (addr == A_PWR) begin
            data = {pwr.freeze, 3'b000, pwr.pd_mic, pwr.pd_adc, pwr.pd_dac, pwr.pd_dev};
        end else begin
            for (int i = 0; i < NFZ; i++) begin
                if (addr == FZ_ADDR[i]) begin
                    data = stg_bytes[i];
                end
            end
        end
    end
endmodule

// File: rtl/ctrl_bank_freeze.sv
module ctrl_bank_freeze
    import ctrlbank_pkg::*;
#(
    parameter logic [3:0] REV = 4'h2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       freeze_on,
    output logic       pd_mic,
    output logic       pd_adc,
    output logic       pd_dac,
    output logic       pd_dev,
    output logic       adc_hold,
    output logic       dac_hold,
    output logic       dac_mute,
    output logic       adc_mute,
    output logic [5:0] gain_a,
    output logic [5:0] gain_b,
    output logic [7:0] vol_a,
    output logic [7:0] vol_b
);
    typedef struct packed {
        pwr_t          pwr;
        logic [DW-1:0] rd;
    } top_t;

    top_t t_d, t_q;
    logic [NFZ-1:0][DW-1:0] stg_bytes;
    logic [NFZ-1:0][DW-1:0] act_bytes;
    logic [DW-1:0]          rd_mux;

    always_comb begin
        t_d = t_q;
        if (wr_en && addr == A_PWR) begin
            t_d.pwr.freeze = wr_data[7];
            t_d.pwr.pd_mic = wr_data[3];
            t_d.pwr.pd_adc = wr_data[2];
            t_d.pwr.pd_dac = wr_data[1];
            t_d.pwr.pd_dev = wr_data[0];
        end
        if (rd_en) begin
            t_d.rd = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '{pwr: PWR_RST, rd: '0};
        end else begin
            t_q <= t_d;
        end
    end

    for (genvar i = 0; i < NFZ; i++) begin : g_fld
        logic [FZ_W[i]-1:0] stg;
        logic [FZ_W[i]-1:0] act;

        ctrlbank_fzfield #(
            .W    (FZ_W[i]),
            .LSB  (FZ_LSB[i]),
            .ADDR (FZ_ADDR[i])
        ) u_fld (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en),
            .addr     (addr),
            .wr_data  (wr_data),
            .freeze_d (t_d.pwr.freeze),
            .staged_q (stg),
            .active_q (act)
        );

        assign stg_bytes[i] = DW'(stg) << FZ_LSB[i];
        assign act_bytes[i] = DW'(act);
    end

    ctrlbank_rdmux #(.REV(REV)) u_rdmux (
        .addr      (addr),
        .pwr       (t_q.pwr),
        .stg_bytes (stg_bytes),
        .data      (rd_mux)
    );

    assign rd_data   = t_q.rd;
    assign freeze_on = t_q.pwr.freeze;
    assign pd_mic    = t_q.pwr.pd_mic;
    assign pd_adc    = t_q.pwr.pd_adc;
    assign pd_dac    = t_q.pwr.pd_dac;
    assign pd_dev    = t_q.pwr.pd_dev;
    assign adc_hold  = t_q.pwr.pd_adc | t_q.pwr.pd_dev;
    assign dac_hold  = t_q.pwr.pd_dac | t_q.pwr.pd_dev;
    assign dac_mute  = act_bytes[0][0];
    assign adc_mute  = act_bytes[1][0];
    assign gain_a    = act_bytes[2][5:0];
    assign gain_b    = act_bytes[3][5:0];
    assign vol_a     = act_bytes[4];
    assign vol_b     = act_bytes[5];
endmodule

// File: rtl/ctrlbank_chk.sv
module ctrlbank_chk #(
    parameter logic [3:0] REV = 4'h2
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] addr,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       freeze_on,
    input logic       pd_dev,
    input logic       adc_hold,
    input logic       dac_hold,
    input logic       dac_mute,
    input logic       adc_mute,
    input logic [5:0] gain_a,
    input logic [5:0] gain_b,
    input logic [7:0] vol_a,
    input logic [7:0] vol_b
);
    logic [29:0] act_all;
    assign act_all = {dac_mute, adc_mute, gain_a, gain_b, vol_a, vol_b};

    logic unfreeze_wr;
    assign unfreeze_wr = wr_en && addr == 8'h02 && !wr_data[7];

    assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (freeze_on && !unfreeze_wr) |=> $stable(act_all));

    assert_direct_write_R4: assert property (@(posedge clk) disable iff (rst)
        (!freeze_on && wr_en && addr == 8'h0A) |=> (vol_a == $past(wr_data)));

    assert_pwr_apply_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h02) |=> (pd_dev == $past(wr_data[0]) && freeze_on == $past(wr_data[7])));

    assert_adc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h02 && (wr_data[2] || wr_data[0])) |=> adc_hold);

    assert_dac_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h02 && (wr_data[1] || wr_data[0])) |=> dac_hold);

    assert_id_read_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 8'h01) |=> (rd_data == {4'hC, REV}));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !$past(rst)) |=> $stable(rd_data));
endmodule

bind ctrl_bank_freeze ctrlbank_chk #(.REV(REV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .freeze_on (freeze_on),
    .pd_dev    (pd_dev),
    .adc_hold  (adc_hold),
    .dac_hold  (dac_hold),
    .dac_mute  (dac_mute),
    .adc_mute  (adc_mute),
    .gain_a    (gain_a),
    .gain_b    (gain_b),
    .vol_a     (vol_a),
    .vol_b     (vol_b)
);

// File: tb/sim_ctrl_bank_freeze.sv
module sim_ctrl_bank_freeze;
    localparam logic [3:0] REV = 4'h2;

    logic       clk = 1'b0;
    logic       rst, wr_en, rd_en;
    logic [7:0] addr, wr_data, rd_data;
    logic       freeze_on, pd_mic, pd_adc, pd_dac, pd_dev, adc_hold, dac_hold;
    logic       dac_mute, adc_mute;
    logic [5:0] gain_a, gain_b;
    logic [7:0] vol_a, vol_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ctrl_bank_freeze #(.REV(REV)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .freeze_on(freeze_on),
        .pd_mic(pd_mic), .pd_adc(pd_adc), .pd_dac(pd_dac), .pd_dev(pd_dev),
        .adc_hold(adc_hold), .dac_hold(dac_hold), .dac_mute(dac_mute),
        .adc_mute(adc_mute), .gain_a(gain_a), .gain_b(gain_b),
        .vol_a(vol_a), .vol_b(vol_b)
    );

    // reference model
    logic [7:0] m_stg [6];
    logic [7:0] m_act [6];
    logic       m_frz, m_mic, m_adc, m_dac, m_dev;

    function automatic int fidx(logic [7:0] a);
        case (a)
            8'h03: return 0;
            8'h04: return 1;
            8'h07: return 2;
            8'h08: return 3;
            8'h0A: return 4;
            8'h0B: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] fmask(int i);
        return (i < 2) ? 8'h04 : (i < 4) ? 8'h3F : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        int i = fidx(a);
        if (a == 8'h01) return {4'hC, REV};
        if (a == 8'h02) return {m_frz, 3'b000, m_mic, m_adc, m_dac, m_dev};
        if (i >= 0) return m_stg[i];
        return 8'h00;
    endfunction

    function automatic logic [36:0] exp_outs();
        return {m_frz, m_mic, m_adc, m_dac, m_dev, m_adc | m_dev, m_dac | m_dev,
                m_act[0][2], m_act[1][2], m_act[2][5:0], m_act[3][5:0], m_act[4], m_act[5]};
    endfunction

    function automatic logic [36:0] got_outs();
        return {freeze_on, pd_mic, pd_adc, pd_dac, pd_dev, adc_hold, dac_hold,
                dac_mute, adc_mute, gain_a, gain_b, vol_a, vol_b};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 6; i++) begin
            m_stg[i] = 8'h00;
            m_act[i] = 8'h00;
        end
        {m_frz, m_mic, m_adc, m_dac} = 4'b0000;
        m_dev = 1'b1;
    endtask

    task automatic model_write(logic [7:0] a, logic [7:0] d);
        int i = fidx(a);
        if (a == 8'h02) begin
            {m_frz, m_mic, m_adc, m_dac, m_dev} = {d[7], d[3:0]};
            if (!m_frz) begin
                for (int k = 0; k < 6; k++) m_act[k] = m_stg[k];
            end
        end else if (i >= 0) begin
            m_stg[i] = d & fmask(i);
            if (!m_frz) m_act[i] = m_stg[i];
        end
    endtask

    task automatic check8(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic check_outs(string tag);
        logic [36:0] g = got_outs();
        logic [36:0] e = exp_outs();
        checks++;
        if (g !== e) begin
            errors++;
            $display("FAIL %s outputs got %h expected %h", tag, g, e);
        end
    endtask

    // called at a negative edge, returns at the next negative edge
    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rdchk(string tag, logic [7:0] a);
        logic [7:0] d;
        rd(a, d);
        check8(tag, d, exp_read(a));
    endtask

    initial begin
        logic [7:0] d, held;
        logic [7:0] alist [12] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05,
                                   8'h07, 8'h08, 8'h0A, 8'h0B, 8'h0C, 8'hFF};
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 8'h00; wr_data = 8'h00;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3 reset state
        check_outs("R3 reset outputs");
        rdchk("R3 reset power reg", 8'h02);
        rdchk("R3 reset gain reg", 8'h07);

        // R1 identification, write ignored
        rdchk("R1 id read", 8'h01);
        wr(8'h01, 8'h5A);
        rdchk("R1 id after write", 8'h01);
        check_outs("R1 outputs after id write");

        // R2 power layout, reserved bits
        wr(8'h02, 8'h7E);
        check_outs("R2 R7 R8 power write");
        rdchk("R2 reserved bits zero", 8'h02);
        check8("R2 pd_mic bit3", {7'b0, pd_mic}, 8'h01);

        // R4 unfrozen writes
        wr(8'h02, 8'h00);
        wr(8'h0A, 8'hA5);
        check_outs("R4 volume direct");
        wr(8'h03, 8'hFF);
        check_outs("R4 R9 dac mute direct");
        rdchk("R9 mute reg masked", 8'h03);
        wr(8'h07, 8'hFF);
        rdchk("R9 gain reg masked", 8'h07);

        // R9 unmapped
        wr(8'h05, 8'h77);
        rdchk("R9 unmapped 05", 8'h05);
        rdchk("R9 unmapped FF", 8'hFF);
        check_outs("R9 outputs after unmapped write");

        // R5 frozen staging
        wr(8'h02, 8'h80);
        wr(8'h04, 8'h04);
        wr(8'h08, 8'h2B);
        wr(8'h0B, 8'hC3);
        wr(8'h0A, 8'h11);
        check_outs("R5 outputs held while frozen");
        rdchk("R5 staged read gain b", 8'h08);
        rdchk("R5 staged read vol b", 8'h0B);

        // R7 power bits apply while frozen
        wr(8'h02, 8'h82);
        check_outs("R7 R8 dac pd while frozen");

        // R6 unfreeze commits all and applies power bits together
        wr(8'h02, 8'h0C);
        check_outs("R6 commit with power change");
        check8("R6 vol_b committed", vol_b, 8'hC3);

        // R10 read data holds
        rd(8'h0B, d);
        held = d;
        addr = 8'h01;
        repeat (3) @(negedge clk);
        check8("R10 rd_data held", rd_data, held);

        // R11 device power-down retains contents
        wr(8'h02, 8'h01);
        check_outs("R11 outputs after device pd");
        rdchk("R11 vol a retained", 8'h0A);
        rdchk("R11 gain b retained", 8'h08);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a = alist[$urandom_range(0, 11)];
            logic [7:0] w = 8'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                wr(a, w);
                check_outs("R4 R5 R6 R7 R8 random write");
            end else begin
                rdchk("R1 R2 R5 R9 R10 random read", a);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule